// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits on the host-processor side of a peripheral controller. A static mode input selects one of two strobe conventions for the same pins. In the separate-strobe convention there is an active-low read line and an active-low write line. In the direction-plus-strobe convention the read line becomes a direction signal (high = read, low = write) and the write line becomes an active-low lower-byte data strobe. Two active-low selects steer a 16-bit, two-lane data bus either to a bank of 32 byte-wide internal registers or to a word-wide DMA data port.

Every host input first passes through a two-flop synchronizer. Each access then yields exactly one single-cycle internal strobe, which fires on the cycle the access becomes active. Register accesses use only the low lane, and the 5-bit address picks the register. DMA accesses use both lanes and ignore the address. Every lane carries an odd-parity bit. The block generates it for each lane it drives on a read and checks it for each lane taken on a write. A mismatch sets a sticky error flag, which the register side clears.

Top module: `hbus_host_if`

## Requirements
- R1: After reset all four strobes are low, both lane output enables are low and the parity error flag is low.
- R2: In separate-strobe mode (bus_mode = 0), register select low with read line low gives one reg_rd_stb. reg_addr equals the address, lane 0 (bits 7:0) is driven with reg_rdata, and lane 1 is not driven (hlane_oe = 2'b01).
- R3: In separate-strobe mode, register select low with write line low gives one reg_wr_stb, and wr_data equals the host data.
- R4: In direction-plus-strobe mode (bus_mode = 1), an access needs the select low and the lower data strobe low. The direction line high makes it a read and low makes it a write. With the strobe high, no strobe fires and no lane is driven.
- R5: DMA select low (register select high) gives dma_rd_stb or dma_wr_stb. A DMA read drives both lanes (hlane_oe = 2'b11) with dma_rdata, whatever the address.
- R6: When both selects are low, only the register strobe fires and the DMA strobe is suppressed.
- R7: On a read, each driven lane's parity bit makes the count of ones in its 8 data bits plus the parity bit odd.
- R8: Parity is checked only on the lanes a write takes: lane 0 for register writes, both lanes for DMA writes. A bad parity bit on an unused lane has no effect.
- R9: par_err is sticky until par_err_clr is high at a clock edge. A new mismatch in the same cycle as a clear wins, and the flag reads 1.
- R10: A held access produces one strobe only. The strobe lasts one cycle.
- R11: Lanes are driven only while a selected read is active, and they are released after it ends.
- R12: A strobe is high in the cycle after the third rising clock edge that follows the input change, counting the two synchronizer flops and the strobe register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | 0 = separate read/write strobes, 1 = direction plus lower data strobe |
| sel_reg_n | input | 1 | Active-low register select |
| sel_dma_n | input | 1 | Active-low DMA port select |
| rd_dir | input | 1 | Read strobe (mode 0) or direction, high = read (mode 1) |
| wr_strb | input | 1 | Write strobe (mode 0) or lower data strobe (mode 1), active low |
| haddr | input | 5 | Register address |
| hdata_i | input | 16 | Host data in |
| hpar_i | input | 2 | Host parity in, one bit per lane |
| hdata_o | output | 16 | Data out to host |
| hpar_o | output | 2 | Parity out to host |
| hlane_oe | output | 2 | Per-lane output enable |
| reg_addr | output | 5 | Synchronized register address |
| reg_rdata | input | 8 | Read data from the register bank |
| reg_rd_stb | output | 1 | Register read strobe |
| reg_wr_stb | output | 1 | Register write strobe |
| dma_rdata | input | 16 | Read data from the DMA port |
| dma_rd_stb | output | 1 | DMA read strobe |
| dma_wr_stb | output | 1 | DMA write strobe |
| wr_data | output | 16 | Synchronized write data |
| par_err | output | 1 | Sticky parity error |
| par_err_clr | input | 1 | Clears par_err |

## Verification
The assertions check on every cycle that the four strobes are mutually exclusive and each one cycle wide, that the parity flag rises only together with a write strobe and holds until cleared, and that driving a lane begins only with a read strobe. The bench's scenarios cover the rest. These are the two strobe conventions, select priority, the address being ignored on DMA reads, lane-selective parity checking, the exact strobe latency and the data and parity values on the lanes.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic {
      BUS_SPLIT  = 1'b0,
      BUS_DIRSTB = 1'b1
   } bus_mode_e;

   typedef struct packed {
      logic reg_rd;
      logic reg_wr;
      logic dma_rd;
      logic dma_wr;
   } acc_t;

   localparam int LANE_W = 8;

   function automatic logic odd_par(input logic [LANE_W-1:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int        W      = 4,
   parameter int        STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
   import hbus_pkg::*;
(
   input  logic bus_mode,
   input  logic sel_reg_n,
   input  logic sel_dma_n,
   input  logic rd_dir,
   input  logic wr_strb,
   output acc_t lvl
);

   logic want_rd;
   logic want_wr;
   logic reg_on;
   logic dma_on;

   always_comb begin
      if (bus_mode_e'(bus_mode) == BUS_DIRSTB) begin
         want_rd = !wr_strb &&  rd_dir;
         want_wr = !wr_strb && !rd_dir;
      end else begin
         want_rd = !rd_dir;
         want_wr = !wr_strb && rd_dir;
      end
   end

   // register select outranks the DMA select
   assign reg_on = !sel_reg_n;
   assign dma_on = !sel_dma_n && sel_reg_n;

   always_comb begin
      lvl.reg_rd = reg_on && want_rd;
      lvl.reg_wr = reg_on && want_wr;
      lvl.dma_rd = dma_on && want_rd;
      lvl.dma_wr = dma_on && want_wr;
   end

endmodule

// File: rtl/hbus_edge.sv
module hbus_edge
   import hbus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  acc_t lvl,
   output acc_t fire,
   output acc_t stb,
   output acc_t lvl_q
);

   assign fire = lvl & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         stb   <= '0;
      end else begin
         lvl_q <= lvl;
         stb   <= fire;
      end
   end

endmodule

// File: rtl/hbus_lanes.sv
module hbus_lanes
   import hbus_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              rd_reg_q,
   input  logic              rd_dma_q,
   input  logic [LANE_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] dma_rdata,
   input  logic              chk_reg,
   input  logic              chk_dma,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  wpar,
   output logic [DATA_W-1:0] hdata_o,
   output logic [LANES-1:0]  hpar_o,
   output logic [LANES-1:0]  hlane_oe,
   output logic [LANES-1:0]  mism
);

   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] rbyte;
         logic              drive;
         logic              take;

         if (i == 0) begin : g_low
            assign drive = rd_dma_q || rd_reg_q;
            assign take  = chk_dma  || chk_reg;
            assign rbyte = rd_dma_q ? dma_rdata[LANE_W-1:0] : reg_rdata;
         end else begin : g_high
            assign drive = rd_dma_q;
            assign take  = chk_dma;
            assign rbyte = dma_rdata[i*LANE_W +: LANE_W];
         end

         assign hlane_oe[i]                 = drive;
         assign hdata_o[i*LANE_W +: LANE_W] = drive ? rbyte : '0;
         assign hpar_o[i]                   = drive ? odd_par(rbyte) : 1'b0;
         assign mism[i] = take &&
                          (wpar[i] != odd_par(wdata[i*LANE_W +: LANE_W]));
      end
   endgenerate

endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
   import hbus_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   localparam int LANES      = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mode,
   input  logic              sel_reg_n,
   input  logic              sel_dma_n,
   input  logic              rd_dir,
   input  logic              wr_strb,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [DATA_W-1:0] hdata_i,
   input  logic [LANES-1:0]  hpar_i,
   output logic [DATA_W-1:0] hdata_o,
   output logic [LANES-1:0]  hpar_o,
   output logic [LANES-1:0]  hlane_oe,
   output logic [ADDR_W-1:0] reg_addr,
   input  logic [LANE_W-1:0] reg_rdata,
   output logic              reg_rd_stb,
   output logic              reg_wr_stb,
   input  logic [DATA_W-1:0] dma_rdata,
   output logic              dma_rd_stb,
   output logic              dma_wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              par_err,
   input  logic              par_err_clr
);

   localparam int CTL_W = 4;
   localparam int PAY_W = ADDR_W + DATA_W + LANES;

   generate
      if (DATA_W % LANE_W != 0 || LANES < 1) begin : g_bad_width
         $error("hbus_host_if: DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("hbus_host_if: ADDR_W must be positive");
      end
   endgenerate

   // control pins idle high
   logic [CTL_W-1:0] ctl_s;
   logic [PAY_W-1:0] pay_s;

   hbus_sync #(
      .W       (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({CTL_W{1'b1}})
   ) ctl_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_reg_n, sel_dma_n, rd_dir, wr_strb}),
      .q     (ctl_s)
   );

   hbus_sync #(
      .W       (PAY_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) pay_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({haddr, hdata_i, hpar_i}),
      .q     (pay_s)
   );

   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] data_s;
   logic [LANES-1:0]  par_s;

   assign {addr_s, data_s, par_s} = pay_s;

   acc_t lvl;
   acc_t fire;
   acc_t stb;
   acc_t lvl_q;

   hbus_decode dec_i (
      .bus_mode  (bus_mode),
      .sel_reg_n (ctl_s[3]),
      .sel_dma_n (ctl_s[2]),
      .rd_dir    (ctl_s[1]),
      .wr_strb   (ctl_s[0]),
      .lvl       (lvl)
   );

   hbus_edge edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .fire  (fire),
      .stb   (stb),
      .lvl_q (lvl_q)
   );

   logic [LANES-1:0] mism;

   hbus_lanes #(
      .DATA_W (DATA_W)
   ) lanes_i (
      .rd_reg_q  (lvl_q.reg_rd),
      .rd_dma_q  (lvl_q.dma_rd),
      .reg_rdata (reg_rdata),
      .dma_rdata (dma_rdata),
      .chk_reg   (fire.reg_wr),
      .chk_dma   (fire.dma_wr),
      .wdata     (data_s),
      .wpar      (par_s),
      .hdata_o   (hdata_o),
      .hpar_o    (hpar_o),
      .hlane_oe  (hlane_oe),
      .mism      (mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          par_err <= 1'b0;
      else if (|mism)      par_err <= 1'b1;
      else if (par_err_clr) par_err <= 1'b0;
   end

   assign reg_rd_stb = stb.reg_rd;
   assign reg_wr_stb = stb.reg_wr;
   assign dma_rd_stb = stb.dma_rd;
   assign dma_wr_stb = stb.dma_wr;
   assign reg_addr   = addr_s;
   assign wr_data    = data_s;

endmodule

// File: rtl/hbus_host_if_chk.sv
module hbus_host_if_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_rd_stb,
   input logic             reg_wr_stb,
   input logic             dma_rd_stb,
   input logic             dma_wr_stb,
   input logic             par_err,
   input logic             par_err_clr,
   input logic [LANES-1:0] hlane_oe
);

   // R6: never a register and a DMA strobe together, nor two of either kind
   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_rd_stb, reg_wr_stb, dma_rd_stb, dma_wr_stb}));

   assert_reg_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |=> !reg_wr_stb);

   assert_reg_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_stb |=> !reg_rd_stb);

   assert_dma_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rd_stb || dma_wr_stb) |=> !(dma_rd_stb || dma_wr_stb));

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> (reg_wr_stb || dma_wr_stb));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !par_err_clr) |=> par_err);

   assert_drive_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlane_oe[0]) |-> (reg_rd_stb || dma_rd_stb));

   assert_upper_needs_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hlane_oe[LANES-1] |-> hlane_oe[0]);

endmodule

bind hbus_host_if hbus_host_if_chk #(.LANES(LANES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_rd_stb  (reg_rd_stb),
   .reg_wr_stb  (reg_wr_stb),
   .dma_rd_stb  (dma_rd_stb),
   .dma_wr_stb  (dma_wr_stb),
   .par_err     (par_err),
   .par_err_clr (par_err_clr),
   .hlane_oe    (hlane_oe)
);

// File: tb/hbus_host_if_tb_top.sv
`timescale 1ns/1ps
module hbus_host_if_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_mode = 1'b0;
   logic        sel_reg_n = 1'b1;
   logic        sel_dma_n = 1'b1;
   logic        rd_dir = 1'b1;
   logic        wr_strb = 1'b1;
   logic [4:0]  haddr = '0;
   logic [15:0] hdata_i = '0;
   logic [1:0]  hpar_i = '0;
   logic [15:0] hdata_o;
   logic [1:0]  hpar_o;
   logic [1:0]  hlane_oe;
   logic [4:0]  reg_addr;
   logic [7:0]  reg_rdata;
   logic        reg_rd_stb;
   logic        reg_wr_stb;
   logic [15:0] dma_rdata = 16'h3C96;
   logic        dma_rd_stb;
   logic        dma_wr_stb;
   logic [15:0] wr_data;
   logic        par_err;
   logic        par_err_clr = 1'b0;

   int vectors = 0;
   int miscompares = 0;

   always #2 clk = ~clk;

   assign reg_rdata = 8'hA0 ^ {3'b000, reg_addr};

   hbus_host_if dut_i (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
      .sel_reg_n(sel_reg_n), .sel_dma_n(sel_dma_n),
      .rd_dir(rd_dir), .wr_strb(wr_strb), .haddr(haddr),
      .hdata_i(hdata_i), .hpar_i(hpar_i), .hdata_o(hdata_o),
      .hpar_o(hpar_o), .hlane_oe(hlane_oe), .reg_addr(reg_addr),
      .reg_rdata(reg_rdata), .reg_rd_stb(reg_rd_stb),
      .reg_wr_stb(reg_wr_stb), .dma_rdata(dma_rdata),
      .dma_rd_stb(dma_rd_stb), .dma_wr_stb(dma_wr_stb),
      .wr_data(wr_data), .par_err(par_err), .par_err_clr(par_err_clr)
   );

   // strobe observation results
   int n_rr, n_rw, n_dr, n_dw, first_at;
   logic err_seen;

   function automatic logic op(input logic [7:0] b);
      return ~(^b);
   endfunction

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input int n);
      n_rr = 0; n_rw = 0; n_dr = 0; n_dw = 0; first_at = 0; err_seen = 1'b0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (reg_rd_stb) n_rr++;
         if (reg_wr_stb) n_rw++;
         if (dma_rd_stb) n_dr++;
         if (dma_wr_stb) n_dw++;
         if (par_err) err_seen = 1'b1;
         if (first_at == 0 && (reg_rd_stb | reg_wr_stb | dma_rd_stb | dma_wr_stb))
            first_at = k;
      end
   endtask

   task automatic idle();
      sel_reg_n = 1'b1; sel_dma_n = 1'b1; rd_dir = 1'b1; wr_strb = 1'b1;
      run(6);
   endtask

   task automatic t_reset();
      check(!(reg_rd_stb | reg_wr_stb | dma_rd_stb | dma_wr_stb), "R1 strobes",
            {reg_rd_stb, reg_wr_stb, dma_rd_stb, dma_wr_stb}, 0);
      check(hlane_oe == 2'b00, "R1 oe", hlane_oe, 0);
      check(!par_err, "R1 par_err", par_err, 0);
   endtask

   task automatic t_split_reg_read();
      logic [7:0] exp;
      bus_mode = 1'b0; haddr = 5'h13; sel_reg_n = 1'b0; rd_dir = 1'b0;
      run(6);
      exp = 8'hA0 ^ 8'h13;
      check(n_rr == 1 && n_rw + n_dr + n_dw == 0, "R2 one reg read strobe", n_rr, 1);
      check(first_at == 3, "R12 strobe latency", first_at, 3);
      check(reg_addr == 5'h13, "R2 reg_addr", reg_addr, 5'h13);
      check(hlane_oe == 2'b01, "R2 lane enables", hlane_oe, 2'b01);
      check(hdata_o[7:0] == exp, "R2 low lane data", hdata_o[7:0], exp);
      check(hpar_o[0] == op(exp), "R7 low lane parity", hpar_o[0], op(exp));
      idle();
      check(hlane_oe == 2'b00, "R11 release after read", hlane_oe, 0);
   endtask

   task automatic t_split_reg_write();
      // good low-lane parity, bad upper-lane parity: ignored on register write
      hdata_i = 16'h715A; hpar_i = {op(8'h71) ^ 1'b1, op(8'h5A)};
      sel_reg_n = 1'b0; wr_strb = 1'b0;
      run(12);
      check(n_rw == 1 && n_rr + n_dr + n_dw == 0, "R3/R10 single write strobe", n_rw, 1);
      check(wr_data == 16'h715A, "R3 wr_data", wr_data, 16'h715A);
      check(!err_seen, "R8 upper lane ignored on reg write", err_seen, 0);
      check(hlane_oe == 2'b00, "R11 no drive on write", hlane_oe, 0);
      idle();
   endtask

   task automatic t_bad_parity();
      hdata_i = 16'h0033; hpar_i = {1'b0, op(8'h33) ^ 1'b1};
      sel_reg_n = 1'b0; wr_strb = 1'b0;
      run(6);
      check(par_err, "R8 low lane mismatch sets flag", par_err, 1);
      idle();
      hpar_i = {1'b0, op(8'h33)};
      sel_reg_n = 1'b0; wr_strb = 1'b0;
      run(6);
      check(par_err, "R9 flag sticky across good write", par_err, 1);
      idle();
      par_err_clr = 1'b1; run(1); par_err_clr = 1'b0; run(1);
      check(!par_err, "R9 flag cleared", par_err, 0);
   endtask

   task automatic t_set_beats_clear();
      par_err_clr = 1'b1;
      hdata_i = 16'h0001; hpar_i = {1'b0, op(8'h01) ^ 1'b1};
      sel_reg_n = 1'b0; wr_strb = 1'b0;
      run(3);
      check(par_err, "R9 set wins over clear", par_err, 1);
      run(1);
      check(!par_err, "R9 clear afterwards", par_err, 0);
      par_err_clr = 1'b0;
      idle();
   endtask

   task automatic t_dma();
      logic [15:0] first_rd;
      dma_rdata = 16'h3C96;
      haddr = 5'h02; sel_dma_n = 1'b0; rd_dir = 1'b0;
      run(6);
      first_rd = hdata_o;
      check(n_dr == 1 && n_rr + n_rw + n_dw == 0, "R5 dma read strobe", n_dr, 1);
      check(hlane_oe == 2'b11, "R5 both lanes driven", hlane_oe, 2'b11);
      check(hdata_o == 16'h3C96, "R5 dma data", hdata_o, 16'h3C96);
      check(hpar_o == {op(8'h3C), op(8'h96)}, "R7 both lane parity", hpar_o,
            {op(8'h3C), op(8'h96)});
      haddr = 5'h1D;
      run(4);
      check(hdata_o == first_rd, "R5 address ignored on dma", hdata_o, first_rd);
      idle();
      hdata_i = 16'h8811; hpar_i = {op(8'h88) ^ 1'b1, op(8'h11)};
      sel_dma_n = 1'b0; wr_strb = 1'b0;
      run(6);
      check(n_dw == 1, "R5 dma write strobe", n_dw, 1);
      check(par_err, "R8 upper lane checked on dma write", par_err, 1);
      idle();
      par_err_clr = 1'b1; run(1); par_err_clr = 1'b0; run(1);
   endtask

   task automatic t_both_selects();
      hdata_i = 16'h0042; hpar_i = {op(8'h00), op(8'h42)};
      sel_reg_n = 1'b0; sel_dma_n = 1'b0; wr_strb = 1'b0;
      run(6);
      check(n_rw == 1, "R6 register strobe wins", n_rw, 1);
      check(n_dw == 0, "R6 dma strobe suppressed", n_dw, 0);
      idle();
   endtask

   task automatic t_dirstb();
      logic [7:0] exp;
      bus_mode = 1'b1;
      haddr = 5'h07; sel_reg_n = 1'b0; rd_dir = 1'b1; wr_strb = 1'b0;
      run(6);
      exp = 8'hA0 ^ 8'h07;
      check(n_rr == 1 && n_rw == 0, "R4 direction high reads", n_rr, 1);
      check(hdata_o[7:0] == exp, "R4 read data", hdata_o[7:0], exp);
      idle();
      hdata_i = 16'h00C3; hpar_i = {op(8'h00), op(8'hC3)};
      sel_reg_n = 1'b0; rd_dir = 1'b0; wr_strb = 1'b0;
      run(6);
      check(n_rw == 1 && n_rr == 0, "R4 direction low writes", n_rw, 1);
      idle();
      sel_reg_n = 1'b0; wr_strb = 1'b1; rd_dir = 1'b1; run(3);
      rd_dir = 1'b0; run(3);
      rd_dir = 1'b1; run(3);
      check(n_rr + n_rw == 0, "R4 no access without data strobe", n_rr + n_rw, 0);
      check(hlane_oe == 2'b00, "R4 no drive without data strobe", hlane_oe, 0);
      idle();
      bus_mode = 1'b0;
      run(2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(4);
      t_reset();
      t_split_reg_read();
      t_split_reg_write();
      t_bad_parity();
      t_set_beats_clear();
      t_dma();
      t_both_selects();
      t_dirstb();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule